// File: doc/BRIEF.md
# Binarized XNOR-Popcount Neuron Layer

This block evaluates one fully unrolled layer of a binarized neural network. Every activation and every weight is a single bit: a 1 stands for +1 and a 0 for -1. Each product is the XNOR of an activation bit and a weight bit. Each output neuron counts how many of its products are 1. It emits a 1 when that count reaches its own programmable threshold. All neurons and all inputs are evaluated in parallel, so the layer needs no multipliers, only XNOR gates, adders and one comparator per neuron.

Weight rows and thresholds live in an internal register array. They are loaded one neuron at a time through a write port. A parameter selects the output timing. In the registered form, the result and its strobe appear one clock after the input. In the combinational form, the result appears in the same cycle, with no storage between input and output. The parameters scale the layer to 512 inputs by 512 outputs. The defaults are kept small.

Top module: `bnn_xnor_layer`

## Requirements
- R1: Output bit o is 1 exactly when the signed sum over inputs j of (+1 if in_act[j] equals weight row o bit j, else -1) is at least 2*threshold[o] - N_IN. Equivalently, the count of agreeing bits is at least threshold[o]. A bit value of 1 encodes +1 and 0 encodes -1.
- R2: The threshold comparison is inclusive: a count equal to the threshold fires, and a count one below it does not.
- R3: A threshold of 0 makes a neuron always fire. A threshold above N_IN (the field is clog2(N_IN)+1 bits wide) makes it never fire.
- R4: A write with wr_kind=0 loads wr_data into the weight row of neuron wr_addr, with bit j being the weight for input j. A write with wr_kind=1 loads wr_data[clog2(N_IN):0] as that neuron's threshold.
- R5: In registered mode, out_valid is high in the cycle after an edge that sampled in_valid high and low otherwise. out_act is updated at that same edge.
- R6: In registered mode, out_act holds its last result while in_valid is low.
- R7: A write at the same edge that samples an input does not affect that input's result. It applies from the next input on.
- R8: In combinational mode, out_valid equals in_valid and out_act carries the result in the same cycle, reading as zero while in_valid is low.
- R9: Reset clears out_valid and out_act, sets every weight bit to 0 (-1) and every threshold to 0.
- R10: A write to one neuron leaves the weights, thresholds and outputs of all other neurons unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the parameter store |
| wr_kind | input | 1 | 0 selects a weight row, 1 selects a threshold |
| wr_addr | input | clog2(N_OUT) | Neuron index to write |
| wr_data | input | N_IN | Weight row, or threshold in the low bits |
| in_valid | input | 1 | Input activation vector is valid |
| in_act | input | N_IN | Input activation bits |
| out_valid | output | 1 | Output vector is valid |
| out_act | output | N_OUT | Output activation bits |

## Verification
Both output timings run side by side on the same stimulus. Results are compared against a signed dot-product model. The input patterns include all-zero and all-one vectors, which separate the reset weight state from an inverted XNOR. Alternating and sparse patterns catch wrong bit ordering within a row. An exact copy of a weight row, and its complement, drive the count to its two ends, exposing an off-by-one at N_IN or at zero. Directed cases set a threshold equal to the live count and then one above it. They also overlap a write with an input, and hold the input idle to show the registered result is retained.

// File: rtl/bnn_xnor_layer.sv
`timescale 1ns/1ps
module bnn_xnor_layer #(
  parameter int N_IN       = 32,
  parameter int N_OUT      = 16,
  parameter bit REGISTERED = 1'b1,
  localparam int CW = $clog2(N_IN) + 1,
  localparam int AW = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_kind,
  input  logic [AW-1:0]    wr_addr,
  input  logic [N_IN-1:0]  wr_data,
  input  logic             in_valid,
  input  logic [N_IN-1:0]  in_act,
  output logic             out_valid,
  output logic [N_OUT-1:0] out_act
);

  logic [N_IN-1:0]  w_q [N_OUT];
  logic [CW-1:0]    t_q [N_OUT];
  logic [N_OUT-1:0] fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int o = 0; o < N_OUT; o++) begin
        w_q[o] <= '0;
        t_q[o] <= '0;
      end
    end else if (wr_en && int'(wr_addr) < N_OUT) begin
      if (wr_kind) t_q[wr_addr] <= wr_data[CW-1:0];
      else         w_q[wr_addr] <= wr_data;
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_n
    logic [N_IN-1:0] agree;
    logic [CW-1:0]   cnt;
    assign agree = ~(in_act ^ w_q[o]);
    always_comb begin
      cnt = '0;
      for (int j = 0; j < N_IN; j++) cnt = cnt + CW'(agree[j]);
    end
    assign fire[o] = (cnt >= t_q[o]);

    if (REGISTERED) begin : g_chk
      // R3: a threshold beyond N_IN can never be reached
      a_r3_unreachable: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && t_q[o] > CW'(N_IN)) |=> !out_act[o]);
    end
  end

  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        out_act   <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) out_act <= fire;
      end
    end

    a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_act));
    a_r9_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> !out_valid);
  end else begin : g_comb
    assign out_valid = in_valid & rst_n;
    assign out_act   = out_valid ? fire : '0;
  end

endmodule

// File: tb/test_bnn_xnor_layer.sv
`timescale 1ns/1ps
module test_bnn_xnor_layer;
  localparam int NI = 32;
  localparam int NO = 16;
  localparam int CW = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, wr_kind = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [NI-1:0] wr_data = '0;
  logic          in_valid = 1'b0;
  logic [NI-1:0] in_act = '0;
  logic          rv, cv;
  logic [NO-1:0] ra, ca;

  bnn_xnor_layer #(.N_IN(NI), .N_OUT(NO), .REGISTERED(1'b1)) i_bnn_xnor_layer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_addr(wr_addr),
    .wr_data(wr_data), .in_valid(in_valid), .in_act(in_act),
    .out_valid(rv), .out_act(ra));

  bnn_xnor_layer #(.N_IN(NI), .N_OUT(NO), .REGISTERED(1'b0)) i_bnn_comb (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_addr(wr_addr),
    .wr_data(wr_data), .in_valid(in_valid), .in_act(in_act),
    .out_valid(cv), .out_act(ca));

  localparam logic [NI-1:0] TV [8] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'hAAAA_AAAA, 32'h5555_5555,
    32'h0000_0001, 32'h8000_0000, 32'h1234_5678, 32'hF0F0_0F0F };

  logic [NI-1:0] m_w [NO];
  int            m_t [NO];
  int n_chk = 0, n_err = 0;

  function automatic logic [NO-1:0] model_out(input logic [NI-1:0] x);
    logic [NO-1:0] r;
    for (int o = 0; o < NO; o++) begin
      int dot = 0;
      for (int j = 0; j < NI; j++) dot += (x[j] == m_w[o][j]) ? 1 : -1;
      r[o] = (dot >= 2 * m_t[o] - NI);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [NO-1:0] got, input logic [NO-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input bit kind, input int addr, input logic [NI-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = kind; wr_addr = 4'(addr); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (kind) m_t[addr] = int'(d[CW-1:0]);
    else      m_w[addr] = d;
  endtask

  task automatic apply(input logic [NI-1:0] x, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_act = x;
    #1;
    check({tag, " R8 comb"}, ca, model_out(x));
    check({tag, " R8 cvalid"}, NO'(cv), NO'(1));
    @(posedge clk); #1;
    check(tag, ra, model_out(x));
    check({tag, " R5 rvalid"}, NO'(rv), NO'(1));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [NO-1:0] held;
    int c;
    for (int o = 0; o < NO; o++) begin m_w[o] = '0; m_t[o] = 0; end
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset valid", NO'(rv), '0);
    check("R9 reset act", ra, '0);
    @(negedge clk) rst_n = 1'b1;

    apply(32'hDEAD_BEEF, "R9 thr zero");
    check("R3 thr zero fires", ra, '1);
    for (int o = 0; o < NO; o++) wr(1'b1, o, NI);
    apply('0, "R9 weights zero");
    apply('1, "R9 weights zero inv");

    for (int o = 0; o < NO; o++) wr(1'b0, o, (32'h9E37_79B9 * (o + 1)) ^ (32'h5BD1_E995 >> o));
    wr(1'b1, 0, 0);
    wr(1'b1, 1, NI + 1);
    wr(1'b1, 2, NI);
    wr(1'b1, 3, 63);
    for (int o = 4; o < NO; o++) wr(1'b1, o, 10 + o);

    for (int k = 0; k < 8; k++) begin
      apply(TV[k], "R1 table");
      check("R3 zero thr", NO'(ra[0]), NO'(1));
      check("R3 high thr", NO'(ra[1] | ra[3]), NO'(0));
    end
    apply(m_w[2], "R1 exact row");
    check("R2 count equals N_IN", NO'(ra[2]), NO'(1));
    apply(~m_w[2], "R1 complement row");

    c = $countones(~(TV[6] ^ m_w[5]));
    wr(1'b1, 5, c);
    apply(TV[6], "R2 equal");
    check("R2 equal fires", NO'(ra[5]), NO'(1));
    wr(1'b1, 5, c + 1);
    apply(TV[6], "R2 above");
    check("R2 one below silent", NO'(ra[5]), NO'(0));

    wr(1'b0, 10, 32'h0000_0001);
    wr(1'b1, 10, NI);
    apply(32'h0000_0001, "R4 bit order");
    check("R4 row bit0 match", NO'(ra[10]), NO'(1));
    apply(32'h0000_0002, "R4 bit order");
    check("R4 row bit1 mismatch", NO'(ra[10]), NO'(0));

    c = $countones(~(TV[7] ^ m_w[6]));
    wr(1'b1, 6, c);
    @(negedge clk);
    in_valid = 1'b1; in_act = TV[7];
    wr_en = 1'b1; wr_kind = 1'b1; wr_addr = 4'd6; wr_data = NI'(c + 1);
    #1;
    check("R7 comb old thr", NO'(ca[6]), NO'(1));
    @(posedge clk); #1;
    check("R7 same edge uses old", NO'(ra[6]), NO'(1));
    @(negedge clk);
    wr_en = 1'b0;
    m_t[6] = c + 1;
    @(posedge clk); #1;
    check("R7 next input uses new", ra, model_out(TV[7]));
    check("R7 neuron6 now silent", NO'(ra[6]), NO'(0));
    held = ra;

    @(negedge clk);
    in_valid = 1'b0; in_act = ~TV[7];
    repeat (3) @(posedge clk);
    #1;
    check("R6 hold act", ra, held);
    check("R5 idle valid", NO'(rv), '0);
    check("R8 comb idle", {ca[NO-2:0], cv}, '0);

    @(negedge clk);
    in_valid = 1'b1; in_act = TV[3];
    #1;
    check("R5 not yet valid", NO'(rv), '0);
    check("R5 not yet updated", ra, held);
    @(posedge clk); #1;
    check("R5 one cycle later", NO'(rv), NO'(1));
    check("R5 result", ra, model_out(TV[3]));
    @(negedge clk) in_valid = 1'b0;
    @(posedge clk); #1;
    check("R5 drops", NO'(rv), '0);

    apply(TV[4], "R10 before");
    held = ra;
    wr(1'b0, 9, ~m_w[9]);
    apply(TV[4], "R10 after");
    check("R10 others unchanged", ra & ~NO'(1 << 9), held & ~NO'(1 << 9));

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule